// File: doc/BRIEF.md
# Conversion Result Window Comparator

This block sits at the end of a converter's result path, after correction, averaging and formatting. It takes each final result together with its valid strobe and tests it against one or two threshold values that software programs. When comparison is turned on, a result is kept only if it meets the selected condition. A kept result is forwarded with a valid strobe, and a match pulse goes with it. A result that fails the test is dropped, so the completion stage downstream never sees it. When comparison is turned off, every result is forwarded unchanged.

Four conditions are available. Two use a single threshold: strictly below threshold A, or at or above threshold A. Two use a window made from both thresholds: inside the window or outside it, with both edges counted as inside. The window is built correctly whichever threshold holds the larger value. A mode input selects whether the result and both thresholds are compared as two's-complement numbers, for differential results, or as unsigned numbers, for single-ended results.

Top module: `result_cmp_unit`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, valid_o and match_o are 0 and data_o is all zeros.
- R2: When cmp_en_i is 0, every cycle with res_valid_i high gives valid_o high one clock later, with data_o equal to res_data_i and match_o low.
- R3: When cmp_en_i is 1 and cmp_mode_i is 2'b00, a result passes only if it is strictly less than cmp_a_i. A result equal to cmp_a_i fails.
- R4: When cmp_en_i is 1 and cmp_mode_i is 2'b01, a result passes if it is greater than or equal to cmp_a_i. A result equal to cmp_a_i passes.
- R5: When cmp_en_i is 1 and cmp_mode_i is 2'b10, a result passes if it lies between the two thresholds, with both ends included.
- R6: When cmp_en_i is 1 and cmp_mode_i is 2'b11, a result passes only if it is below the lower threshold or above the upper threshold. A result equal to either threshold fails.
- R7: The window modes give the same outcome whichever of cmp_a_i and cmp_b_i holds the larger value.
- R8: When signed_i is 1, the result and both thresholds are read as two's-complement numbers. When signed_i is 0, they are read as unsigned numbers.
- R9: When cmp_en_i is 1 and a result fails, valid_o and match_o stay low in the next cycle, and data_o keeps the last result that was forwarded.
- R10: Outputs follow the input after exactly one clock. valid_o and match_o are high for one cycle per accepted input, and they are never high in a cycle after one where res_valid_i was low.
- R11: In modes 2'b00 and 2'b01, the value of cmp_b_i has no effect on the outputs.
- R12: match_o is high exactly when a result was accepted with cmp_en_i set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_valid_i | input | 1 | Strobe marking a final conversion result |
| res_data_i | input | DW | Final conversion result |
| cmp_en_i | input | 1 | Turns the compare gate on |
| cmp_mode_i | input | 2 | Condition: 00 below A, 01 at or above A, 10 inside window, 11 outside window |
| signed_i | input | 1 | 1 selects a two's-complement compare, 0 an unsigned compare |
| cmp_a_i | input | DW | Threshold A |
| cmp_b_i | input | DW | Threshold B, used only in the window modes |
| valid_o | output | 1 | Strobe for a result that passed the gate |
| data_o | output | DW | Last result that passed the gate |
| match_o | output | 1 | Condition met on an accepted result with compare turned on |

## Verification
The hardest cases to reach from the ports are results that sit exactly on a threshold, especially when signedness changes the order of the values. One example is a window whose bounds straddle zero, with the thresholds given in reverse order. Random values over the full range almost never land on such an edge. The stimulus therefore uses directed steps that place the result on each bound, one below it and one above it, in both signedness modes and with the thresholds swapped. A random phase then draws thresholds from a narrow band and often copies a threshold into the result, so equality cases keep recurring under every mode.

// File: rtl/result_cmp_pkg.sv
package result_cmp_pkg;
  typedef enum logic [1:0] {
    CMP_LT      = 2'b00,
    CMP_GE      = 2'b01,
    CMP_INSIDE  = 2'b10,
    CMP_OUTSIDE = 2'b11
  } cmp_mode_e;

  localparam int unsigned NUM_KEYS = 3;  // result, threshold a, threshold b
endpackage

// File: rtl/rcmp_key.sv
// Maps a value onto an unsigned ordering key: flipping the sign bit makes
// two's-complement order equal to unsigned order.
module rcmp_key #(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] val_i,
  input  logic          signed_i,
  output logic [DW-1:0] key_o
);
  always_comb begin
    key_o         = val_i;
    key_o[DW-1]   = val_i[DW-1] ^ signed_i;
  end
endmodule

// File: rtl/rcmp_bounds.sv
module rcmp_bounds #(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] key_a_i,
  input  logic [DW-1:0] key_b_i,
  output logic [DW-1:0] lo_o,
  output logic [DW-1:0] hi_o
);
  logic swap;
  assign swap = key_a_i > key_b_i;
  assign lo_o = swap ? key_b_i : key_a_i;
  assign hi_o = swap ? key_a_i : key_b_i;
endmodule

// File: rtl/rcmp_eval.sv
module rcmp_eval
  import result_cmp_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  cmp_mode_e     mode_i,
  input  logic [DW-1:0] key_res_i,
  input  logic [DW-1:0] key_a_i,
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hi_i,
  output logic          hit_o
);
  logic below_a, in_win;
  assign below_a = key_res_i < key_a_i;
  assign in_win  = (key_res_i >= lo_i) && (key_res_i <= hi_i);

  always_comb begin
    unique case (mode_i)
      CMP_LT:      hit_o = below_a;
      CMP_GE:      hit_o = !below_a;
      CMP_INSIDE:  hit_o = in_win;
      CMP_OUTSIDE: hit_o = !in_win;
      default:     hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rcmp_out_stage.sv
module rcmp_out_stage #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          en_i,
  input  logic          hit_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic          match_o
);
  logic accept;
  assign accept = in_valid_i && (!en_i || hit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      match_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= accept;
      match_o <= accept && en_i;
      if (accept) data_o <= in_data_i;
    end
  end
endmodule

// File: rtl/result_cmp_unit.sv
module result_cmp_unit
  import result_cmp_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          res_valid_i,
  input  logic [DW-1:0] res_data_i,
  input  logic          cmp_en_i,
  input  logic [1:0]    cmp_mode_i,
  input  logic          signed_i,
  input  logic [DW-1:0] cmp_a_i,
  input  logic [DW-1:0] cmp_b_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic          match_o
);
  logic [NUM_KEYS-1:0][DW-1:0] raw, key;
  logic [DW-1:0] lo, hi;
  logic          hit;

  assign raw[0] = res_data_i;
  assign raw[1] = cmp_a_i;
  assign raw[2] = cmp_b_i;

  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_key
    rcmp_key #(.DW(DW)) u_key (
      .val_i   (raw[g]),
      .signed_i(signed_i),
      .key_o   (key[g])
    );
  end

  rcmp_bounds #(.DW(DW)) u_bounds (
    .key_a_i(key[1]),
    .key_b_i(key[2]),
    .lo_o   (lo),
    .hi_o   (hi)
  );

  rcmp_eval #(.DW(DW)) u_eval (
    .mode_i   (cmp_mode_e'(cmp_mode_i)),
    .key_res_i(key[0]),
    .key_a_i  (key[1]),
    .lo_i     (lo),
    .hi_i     (hi),
    .hit_o    (hit)
  );

  rcmp_out_stage #(.DW(DW)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_valid_i(res_valid_i),
    .in_data_i (res_data_i),
    .en_i      (cmp_en_i),
    .hit_i     (hit),
    .valid_o   (valid_o),
    .data_o    (data_o),
    .match_o   (match_o)
  );
endmodule

// File: rtl/result_cmp_unit_chk.sv
module result_cmp_unit_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          res_valid_i,
  input logic [DW-1:0] res_data_i,
  input logic          cmp_en_i,
  input logic          valid_o,
  input logic [DW-1:0] data_o,
  input logic          match_o
);
  AST_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && !cmp_en_i) |=> (valid_o && !match_o && data_o == $past(res_data_i))); // R2

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |=> (!valid_o && !match_o)); // R10

  AST_MATCH_IFF_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && cmp_en_i) |=> (match_o == valid_o)); // R12

  AST_HOLD_ON_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o)); // R9

  AST_MATCH_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> valid_o); // R12
endmodule

bind result_cmp_unit result_cmp_unit_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .res_valid_i(res_valid_i),
  .res_data_i (res_data_i),
  .cmp_en_i   (cmp_en_i),
  .valid_o    (valid_o),
  .data_o     (data_o),
  .match_o    (match_o)
);

// File: tb/tb_result_cmp_unit.sv
`timescale 1ns/1ps
module tb_result_cmp_unit;
  localparam int DW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          res_valid_i = 1'b0;
  logic [DW-1:0] res_data_i = '0;
  logic          cmp_en_i = 1'b0;
  logic [1:0]    cmp_mode_i = 2'b00;
  logic          signed_i = 1'b0;
  logic [DW-1:0] cmp_a_i = '0;
  logic [DW-1:0] cmp_b_i = '0;
  logic          valid_o, match_o;
  logic [DW-1:0] data_o;

  int checks = 0;
  int errors = 0;

  logic          exp_valid = 1'b0, exp_match = 1'b0;
  logic [DW-1:0] exp_data = '0;
  string         exp_tag = "R1";

  always #10 clk_i = ~clk_i;

  result_cmp_unit #(.DW(DW)) dut (.*);

  function automatic int to_int(logic [DW-1:0] v, logic sg);
    if (sg) return int'($signed(v));
    return int'(v);
  endfunction

  function automatic bit ref_hit(logic [DW-1:0] d, logic [1:0] m, logic sg,
                                 logic [DW-1:0] a, logic [DW-1:0] b);
    int x = to_int(d, sg);
    int p = to_int(a, sg);
    int q = to_int(b, sg);
    int lo = (p < q) ? p : q;
    int hi = (p < q) ? q : p;
    case (m)
      2'b00:   return x < p;
      2'b01:   return x >= p;
      2'b10:   return (x >= lo) && (x <= hi);
      default: return (x < lo) || (x > hi);
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_outputs();
    chk(exp_tag, "valid_o", int'(valid_o), int'(exp_valid));
    chk(exp_tag, "match_o", int'(match_o), int'(exp_match));
    chk(exp_tag, "data_o",  int'(data_o),  int'(exp_data));
  endtask

  // drive at negedge, compare the previous step's expectation first
  task automatic step(string tag, logic v, logic [DW-1:0] d, logic en, logic [1:0] m,
                      logic sg, logic [DW-1:0] a, logic [DW-1:0] b);
    bit acc;
    @(negedge clk_i);
    compare_outputs();
    res_valid_i = v; res_data_i = d; cmp_en_i = en; cmp_mode_i = m;
    signed_i = sg; cmp_a_i = a; cmp_b_i = b;
    acc = v && (!en || ref_hit(d, m, sg, a, b));
    exp_valid = acc;
    exp_match = acc && en;
    if (acc) exp_data = d;
    exp_tag = tag;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    // R1: reset state, during and just after release
    repeat (3) @(negedge clk_i);
    compare_outputs();
    rst_ni = 1'b1;
    step("R1", 0, 16'h0000, 0, 2'b00, 0, 16'h0000, 16'h0000);

    // R2: compare off, everything passes
    step("R2", 1, 16'h1234, 0, 2'b00, 0, 16'h0000, 16'h0000);
    step("R2", 1, 16'hFFFF, 0, 2'b11, 1, 16'h0005, 16'h0006);
    step("R10", 0, 16'hAAAA, 0, 2'b00, 0, 16'h0000, 16'h0000);

    // R3: strictly less than a
    step("R3", 1, 16'd99,  1, 2'b00, 0, 16'd100, 16'd0);
    step("R3", 1, 16'd100, 1, 2'b00, 0, 16'd100, 16'd0);
    step("R9", 0, 16'd0,   1, 2'b00, 0, 16'd100, 16'd0);
    // R4: at or above a
    step("R4", 1, 16'd100, 1, 2'b01, 0, 16'd100, 16'd0);
    step("R4", 1, 16'd99,  1, 2'b01, 0, 16'd100, 16'd0);
    step("R4", 1, 16'd101, 1, 2'b01, 0, 16'd100, 16'd0);
    // R11: b irrelevant in single-threshold modes
    step("R11", 1, 16'd50, 1, 2'b00, 0, 16'd100, 16'd10);
    step("R11", 1, 16'd50, 1, 2'b00, 0, 16'd100, 16'hFFFF);
    step("R11", 1, 16'd150, 1, 2'b01, 0, 16'd100, 16'd0);
    // R5: inside, inclusive
    step("R5", 1, 16'd10, 1, 2'b10, 0, 16'd10, 16'd20);
    step("R5", 1, 16'd20, 1, 2'b10, 0, 16'd10, 16'd20);
    step("R5", 1, 16'd9,  1, 2'b10, 0, 16'd10, 16'd20);
    step("R5", 1, 16'd21, 1, 2'b10, 0, 16'd10, 16'd20);
    // R6: outside, bounds excluded
    step("R6", 1, 16'd10, 1, 2'b11, 0, 16'd10, 16'd20);
    step("R6", 1, 16'd9,  1, 2'b11, 0, 16'd10, 16'd20);
    step("R6", 1, 16'd21, 1, 2'b11, 0, 16'd10, 16'd20);
    step("R6", 1, 16'd20, 1, 2'b11, 0, 16'd10, 16'd20);
    // R7: swapped bounds
    step("R7", 1, 16'd15, 1, 2'b10, 0, 16'd20, 16'd10);
    step("R7", 1, 16'd20, 1, 2'b10, 0, 16'd20, 16'd10);
    step("R7", 1, 16'd5,  1, 2'b11, 0, 16'd20, 16'd10);
    step("R7", 1, 16'd10, 1, 2'b11, 0, 16'd20, 16'd10);
    // R8: signed window straddling zero, given reversed
    step("R8", 1, 16'hFFFE, 1, 2'b10, 1, 16'd3, 16'hFFFB);
    step("R8", 1, 16'hFFFE, 1, 2'b10, 0, 16'd3, 16'hFFFB);
    step("R8", 1, 16'h8000, 1, 2'b00, 1, 16'h0000, 16'd0);
    step("R8", 1, 16'h8000, 1, 2'b00, 0, 16'h0000, 16'd0);
    step("R8", 1, 16'hFFFB, 1, 2'b11, 1, 16'd3, 16'hFFFB);
    // R9: failures keep old data
    step("R9", 1, 16'd500, 1, 2'b00, 0, 16'd1, 16'd0);
    step("R9", 1, 16'd600, 1, 2'b10, 0, 16'd1, 16'd2);
    step("R12", 1, 16'd700, 0, 2'b10, 0, 16'd1, 16'd2);

    // random phase with narrow thresholds
    for (int i = 0; i < 4000; i++) begin
      logic [DW-1:0] a, b, d;
      logic [1:0] m;
      logic sg;
      int r;
      m  = 2'($urandom_range(0, 3));
      sg = 1'($urandom_range(0, 1));
      a  = DW'($urandom_range(0, 24)) - DW'(12);
      b  = DW'($urandom_range(0, 24)) - DW'(12);
      r  = $urandom_range(0, 5);
      d  = (r == 0) ? a : (r == 1) ? b : (r == 2) ? DW'($urandom) :
           DW'($urandom_range(0, 30)) - DW'(15);
      case (m)
        2'b00:   step("R3", 1'($urandom_range(0, 3) != 0), d, 1'($urandom_range(0, 4) != 0), m, sg, a, b);
        2'b01:   step("R4", 1'($urandom_range(0, 3) != 0), d, 1'($urandom_range(0, 4) != 0), m, sg, a, b);
        2'b10:   step("R5", 1'($urandom_range(0, 3) != 0), d, 1'($urandom_range(0, 4) != 0), m, sg, a, b);
        default: step("R6", 1'($urandom_range(0, 3) != 0), d, 1'($urandom_range(0, 4) != 0), m, sg, a, b);
      endcase
    end
    step("R10", 0, 16'd0, 0, 2'b00, 0, 16'd0, 16'd0);
    @(negedge clk_i);
    compare_outputs();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule